// File: doc/BRIEF.md
# Framing Error Tally with Host Snapshot Buffer

This block counts received frames whose alignment bits were found wrong. The count lives in a 16-bit live register. A separate hold register is what the host sees through a byte-wide read port, one byte per address. An upstream framer supplies one error pulse per bad frame and an in-sync level. An alarm-simulation flag makes each error count double, and a one-second tick comes from a timebase elsewhere.

The hold register has two update policies. In the tracking policy the hold register mirrors the live count on every clock. The host sets a freeze bit to take a snapshot: while the bit is set the hold register keeps its value, and the live count restarts from zero. Reading the upper byte releases the freeze bit. In the per-second policy the live count moves into the hold register on every tick and restarts from zero. The host then has a full second to read a stable value.

Top module: `ferr_tally`

## Requirements
- R1: A synchronous active-high reset `rst` leaves the live count at zero, the hold register at zero (both read bytes give 0x00) and the freeze bit clear.
- R2: With `in_sync` high and `sim_active` low, each cycle with `err_pulse` high adds one to the live count.
- R3: An `err_pulse` in a cycle with `in_sync` low leaves the live count unchanged.
- R4: With `sim_active` high, a qualified error adds two to the live count.
- R5: The live count stops at 0xFFFF and never wraps. An increment of two from 0xFFFE also gives 0xFFFF.
- R6: With `latch_mode` = 0 and the freeze bit clear, the hold register equals the live count after every clock edge.
- R7: A one-cycle `frz_set` sets the freeze bit, which reads back on `frz_state`. With `latch_mode` = 0, the edge after the bit becomes set clears the live count. The hold register keeps its value while the bit stays set, and a bit that stays high does not clear the count again.
- R8: A cycle with `rd_en` high and `rd_addr` = 1 (the upper byte) clears the freeze bit, and tracking resumes on the next edge. A read with `rd_addr` = 0 leaves the bit set. A clear and a set in the same cycle leave the bit clear.
- R9: With `latch_mode` = 1, a `sec_tick` copies the live count into the hold register and clears the live count. Between ticks the hold register does not change, and the freeze bit has no effect on either register.
- R10: An error that arrives in the same cycle as a live-count clear (freeze edge or tick) becomes the first count after the clear: 1, or 2 with `sim_active`.
- R11: `rd_data` is combinational from the hold register. `rd_addr` = 0 returns bits 7:0 and `rd_addr` = 1 returns bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| err_pulse | input | 1 | One bad frame detected this cycle |
| in_sync | input | 1 | Receiver is frame-synchronous |
| sim_active | input | 1 | Alarm simulation running; errors count twice |
| sec_tick | input | 1 | One-cycle pulse once per second |
| latch_mode | input | 1 | 0 = tracking with host freeze, 1 = per-second capture |
| frz_set | input | 1 | Host write that sets the freeze bit |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 1 | Byte select: 0 low, 1 high |
| rd_data | output | 8 | Selected byte of the hold register |
| frz_state | output | 1 | Current freeze bit |

## Verification
The properties assume that every input is synchronous to `clk` and carries no X after reset. They also assume that `latch_mode` is a configuration level that stays put while events are in flight, because a switch of policy in the middle of a freeze edge changes which clear applies. The stimulus changes inputs only one nanosecond after a rising edge and holds `latch_mode` constant through each phase. It drives `sec_tick` and `frz_set` as single-cycle pulses. A behavioural model checks the read port and the freeze bit on every cycle, and that includes the cycles where a clear and an error coincide.

// File: rtl/ferr_pkg.sv
`timescale 1ns/1ps
package ferr_pkg;

    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int NBYTES = CNT_W / BYTE_W;
    localparam int ADDR_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    typedef logic [CNT_W-1:0] count_t;

    localparam count_t CNT_MAX = {CNT_W{1'b1}};

    typedef enum logic {
        UPD_LIVE   = 1'b0,
        UPD_SECOND = 1'b1
    } upd_mode_e;

    typedef struct packed {
        logic hit;
        logic dbl;
    } err_evt_t;

    function automatic logic [1:0] ev_weight(err_evt_t e);
        if (!e.hit)
            return 2'd0;
        return e.dbl ? 2'd2 : 2'd1;
    endfunction

    function automatic count_t sat_add(count_t a, logic [1:0] w);
        logic [CNT_W:0] s;
        s = {1'b0, a} + {{(CNT_W-1){1'b0}}, w};
        return s[CNT_W] ? CNT_MAX : s[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/ferr_event_qual.sv
`timescale 1ns/1ps
module ferr_event_qual
    import ferr_pkg::*;
(
    input  logic     err_pulse,
    input  logic     in_sync,
    input  logic     sim_active,
    output err_evt_t evt
);

    // An error only counts while frame-synchronous; simulation doubles it.
    always_comb begin
        evt.hit = err_pulse & in_sync;
        evt.dbl = sim_active;
    end

endmodule

// File: rtl/ferr_freeze_ctl.sv
`timescale 1ns/1ps
module ferr_freeze_ctl (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic hi_read,
    output logic frz,
    output logic frz_rise
);

    logic frz_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            frz      <= 1'b0;
            frz_prev <= 1'b0;
        end else begin
            frz_prev <= frz;
            if (hi_read)
                frz <= 1'b0;
            else if (set_req)
                frz <= 1'b1;
        end
    end

    // Edge against the registered copy: a held bit fires only once.
    assign frz_rise = frz & ~frz_prev;

endmodule

// File: rtl/ferr_count_core.sv
`timescale 1ns/1ps
module ferr_count_core
    import ferr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  err_evt_t  evt,
    input  upd_mode_e mode,
    input  logic      frz,
    input  logic      frz_rise,
    input  logic      sec_tick,
    output count_t    live_q,
    output count_t    hold_q,
    output logic      clr_evt
);

    count_t     live_d;
    count_t     hold_d;
    logic [1:0] w;

    always_comb begin
        w       = ev_weight(evt);
        clr_evt = (mode == UPD_SECOND) ? sec_tick : frz_rise;
        // A clear wins; a coincident error becomes the first new count.
        live_d  = clr_evt ? {{(CNT_W-2){1'b0}}, w} : sat_add(live_q, w);

        hold_d = hold_q;
        if (mode == UPD_LIVE) begin
            if (!frz)
                hold_d = live_d;
        end else if (sec_tick) begin
            hold_d = live_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
            hold_q <= '0;
        end else begin
            live_q <= live_d;
            hold_q <= hold_d;
        end
    end

endmodule

// File: rtl/ferr_tally.sv
`timescale 1ns/1ps
module ferr_tally
    import ferr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              err_pulse,
    input  logic              in_sync,
    input  logic              sim_active,
    input  logic              sec_tick,
    input  logic              latch_mode,
    input  logic              frz_set,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              frz_state
);

    localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(NBYTES - 1);

    err_evt_t    evt;
    upd_mode_e   mode;
    logic        hi_read;
    logic        frz;
    logic        frz_rise;
    logic        clr_evt;
    count_t      live_q;
    count_t      hold_q;
    logic [BYTE_W-1:0] byte_lane [NBYTES];

    assign mode    = upd_mode_e'(latch_mode);
    assign hi_read = rd_en && (rd_addr == HI_ADDR);

    ferr_event_qual u_qual (
        .err_pulse  (err_pulse),
        .in_sync    (in_sync),
        .sim_active (sim_active),
        .evt        (evt)
    );

    ferr_freeze_ctl u_frz (
        .clk      (clk),
        .rst      (rst),
        .set_req  (frz_set),
        .hi_read  (hi_read),
        .frz      (frz),
        .frz_rise (frz_rise)
    );

    ferr_count_core u_core (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .mode     (mode),
        .frz      (frz),
        .frz_rise (frz_rise),
        .sec_tick (sec_tick),
        .live_q   (live_q),
        .hold_q   (hold_q),
        .clr_evt  (clr_evt)
    );

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign byte_lane[g] = hold_q[g*BYTE_W +: BYTE_W];
    end

    assign rd_data   = byte_lane[rd_addr];
    assign frz_state = frz;

endmodule

// File: rtl/ferr_tally_chk.sv
`timescale 1ns/1ps
module ferr_tally_chk
    import ferr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              err_pulse,
    input logic              in_sync,
    input logic              sim_active,
    input logic              sec_tick,
    input logic              latch_mode,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              frz_state,
    input count_t            live_q,
    input count_t            hold_q,
    input logic              clr_evt
);

    localparam count_t NEAR_MAX = CNT_MAX - count_t'(1);
    localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(NBYTES - 1);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (live_q == '0 && hold_q == '0 && !frz_state));

    assert_step_R2_R4: assert property (@(posedge clk) disable iff (rst)
        (in_sync && err_pulse && !clr_evt && live_q < NEAR_MAX) |=>
            live_q == $past(live_q) + ($past(sim_active) ? count_t'(2) : count_t'(1)));

    assert_no_count_unsync_R3: assert property (@(posedge clk) disable iff (rst)
        (!(in_sync && err_pulse) && !clr_evt) |=> $stable(live_q));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (live_q == CNT_MAX && !clr_evt) |=> live_q == CNT_MAX);

    assert_live_track_R6: assert property (@(posedge clk) disable iff (rst)
        (!latch_mode && !frz_state) |=> hold_q == live_q);

    assert_freeze_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!latch_mode && frz_state) |=> $stable(hold_q));

    assert_hi_read_release_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == HI_ADDR) |=> !frz_state);

    assert_sec_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (latch_mode && !sec_tick) |=> $stable(hold_q));

    assert_sec_capture_R9: assert property (@(posedge clk) disable iff (rst)
        (latch_mode && sec_tick) |=> hold_q == $past(live_q));

    assert_clear_priority_R10: assert property (@(posedge clk) disable iff (rst)
        (clr_evt && in_sync && err_pulse) |=>
            live_q == ($past(sim_active) ? count_t'(2) : count_t'(1)));

endmodule

bind ferr_tally ferr_tally_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .err_pulse  (err_pulse),
    .in_sync    (in_sync),
    .sim_active (sim_active),
    .sec_tick   (sec_tick),
    .latch_mode (latch_mode),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .frz_state  (frz_state),
    .live_q     (live_q),
    .hold_q     (hold_q),
    .clr_evt    (clr_evt)
);

// File: tb/ferr_tally_tb.sv
`timescale 1ns/1ps
module ferr_tally_tb;
    import ferr_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic err_pulse = 1'b0, in_sync = 1'b1, sim_active = 1'b0;
    logic sec_tick = 1'b0, latch_mode = 1'b0, frz_set = 1'b0, rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [BYTE_W-1:0] rd_data;
    logic frz_state;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ferr_tally u_dut (
        .clk(clk), .rst(rst), .err_pulse(err_pulse), .in_sync(in_sync),
        .sim_active(sim_active), .sec_tick(sec_tick), .latch_mode(latch_mode),
        .frz_set(frz_set), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .frz_state(frz_state)
    );

    // Behavioural reference, updated at each rising edge.
    int m_cnt = 0, m_hold = 0;
    bit m_frz = 1'b0, m_frzp = 1'b0;

    always @(posedge clk) begin
        int inc, nxt;
        bit rise, clr;
        if (rst) begin
            m_cnt = 0; m_hold = 0; m_frz = 1'b0; m_frzp = 1'b0;
        end else begin
            inc  = (err_pulse && in_sync) ? (sim_active ? 2 : 1) : 0;
            rise = m_frz && !m_frzp;
            clr  = latch_mode ? sec_tick : rise;
            nxt  = clr ? inc : ((m_cnt + inc > 65535) ? 65535 : m_cnt + inc);
            if (!latch_mode) begin
                if (!m_frz) m_hold = nxt;
            end else if (sec_tick) begin
                m_hold = m_cnt;
            end
            m_cnt  = nxt;
            m_frzp = m_frz;
            if (rd_en && rd_addr == 1'b1) m_frz = 1'b0;
            else if (frz_set)             m_frz = 1'b1;
        end
    end

    // Every-cycle comparison, away from the rising edge.
    always @(negedge clk) begin
        logic [7:0] eb;
        if (!rst && !done) begin
            eb = rd_addr ? m_hold[15:8] : m_hold[7:0];
            checks++;
            if (rd_data !== eb) begin
                errors++;
                $display("FAIL R11 read byte: actual 0x%0h expected 0x%0h", rd_data, eb);
            end
            checks++;
            if (frz_state !== m_frz) begin
                errors++;
                $display("FAIL R8 freeze bit: actual %0d expected %0d", frz_state, m_frz);
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick_edge();
        @(posedge clk); #1;
    endtask

    task automatic rd_word(output int v);
        logic [7:0] lo, hi;
        tick_edge(); rd_en = 1'b0; rd_addr = 1'b0;
        @(negedge clk); lo = rd_data;
        tick_edge(); rd_addr = 1'b1;
        @(negedge clk); hi = rd_data;
        v = {16'h0, hi, lo};
    endtask

    task automatic errs(int n, bit s);
        repeat (n) begin tick_edge(); err_pulse = 1'b1; sim_active = s; end
        tick_edge(); err_pulse = 1'b0; sim_active = 1'b0;
    endtask

    task automatic pulse_freeze();
        tick_edge(); frz_set = 1'b1;
        tick_edge(); frz_set = 1'b0;
    endtask

    task automatic hi_clear();
        tick_edge(); rd_en = 1'b1; rd_addr = 1'b1;
        tick_edge(); rd_en = 1'b0;
    endtask

    task automatic pulse_tick();
        tick_edge(); sec_tick = 1'b1;
        tick_edge(); sec_tick = 1'b0;
    endtask

    task automatic chk_frz(string tag, int exp);
        @(negedge clk);
        chk(tag, int'(frz_state), exp);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        rd_word(v);              chk("R1 reset word", v, 0);
        chk_frz("R1 reset freeze", 0);

        errs(5, 1'b0);  rd_word(v); chk("R2 R6 five errors", v, 5);
        in_sync = 1'b0;
        errs(3, 1'b0);
        in_sync = 1'b1; rd_word(v); chk("R3 unsync ignored", v, 5);
        errs(2, 1'b1);  rd_word(v); chk("R4 doubled", v, 9);

        pulse_freeze();
        errs(3, 1'b0);
        chk_frz("R7 freeze set", 1);
        rd_word(v);              chk("R7 hold frozen", v, 9);
        tick_edge(); rd_en = 1'b1; rd_addr = 1'b0;
        tick_edge(); rd_en = 1'b0;
        chk_frz("R8 low read keeps freeze", 1);
        hi_clear();
        chk_frz("R8 high read releases", 0);
        rd_word(v);              chk("R8 R7 tracking resumes once cleared", v, 3);

        tick_edge(); frz_set = 1'b1;
        tick_edge(); frz_set = 1'b0; err_pulse = 1'b1;
        tick_edge(); err_pulse = 1'b0;
        hi_clear();
        rd_word(v);              chk("R10 freeze edge with error", v, 1);

        pulse_freeze();
        tick_edge();
        hi_clear();
        errs(65534, 1'b0);
        rd_word(v);              chk("R11 R5 near max bytes", v, 16'hFFFE);
        errs(1, 1'b1);  rd_word(v); chk("R5 double clips", v, 16'hFFFF);
        errs(3, 1'b1);  rd_word(v); chk("R5 stays saturated", v, 16'hFFFF);

        tick_edge(); latch_mode = 1'b1;
        pulse_tick();
        errs(4, 1'b0);  rd_word(v); chk("R9 stable between ticks", v, 16'hFFFF);
        pulse_tick();   rd_word(v); chk("R9 tick capture", v, 4);
        errs(2, 1'b0);
        tick_edge(); sec_tick = 1'b1; err_pulse = 1'b1; sim_active = 1'b1;
        tick_edge(); sec_tick = 1'b0; err_pulse = 1'b0; sim_active = 1'b0;
        rd_word(v);              chk("R9 capture before coincident error", v, 2);
        pulse_tick();   rd_word(v); chk("R10 tick with error", v, 2);

        errs(1, 1'b0);
        pulse_freeze();
        tick_edge(); tick_edge();
        errs(2, 1'b0);
        rd_word(v);              chk("R9 freeze ignored hold", v, 2);
        chk_frz("R7 freeze bit settable", 1);
        pulse_tick();   rd_word(v); chk("R9 freeze did not clear", v, 3);

        tick_edge(); rst = 1'b1;
        tick_edge(); rst = 1'b0;
        rd_word(v);              chk("R1 mid-run reset word", v, 0);
        chk_frz("R1 mid-run reset freeze", 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule